// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Controller

This block gathers interrupt events from a real-time clock's timekeeping logic and drives a single active-low interrupt request line. Six event sources feed it by default. Three of them are primary sources. Their flags sit in a primary status word and are cleared by reading that word. The other three are extended sources. Their flags sit in an extended status word and are cleared only when software writes a zero to the bit. Each group has its own enable word. A source takes part in the request line only while both its flag and its enable are 1.

Software reaches the four words over a small register bus. A write takes effect in the cycle in which `wr_en` is high. A read cycle lasts as long as `rd_en` stays high. The block latches the read word at the rising edge of `rd_en` and holds it steady for the whole read.

A read of the primary status word clears the primary flags when `rd_en` falls. Primary events that arrive during such a read are kept in a side register, so the clear cannot lose them. They are posted into the flags at the same falling edge.

The primary status word also carries a summary bit. It is 1 whenever any enabled source is requesting.

Register selector `addr`:
- 0: primary enable
- 1: primary status
- 2: extended enable
- 3: extended status

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, every flag and every enable reads 0 and `irq_n` is 1.
- R2: An event pulse sets its flag on the next clock edge whether or not its enable is set. With no read in progress, the flag then reads as 1.
- R3: `irq_n` is 0 exactly while some source has both its flag and its enable at 1 (combinational variant). Clearing the enable of a flagged source releases the line.
- R4: Writing 1 to the enable of a source whose flag is already set drives `irq_n` low in the cycle after the write.
- R5: Read data appears one cycle after `rd_en` rises and stays unchanged while `rd_en` stays high. The primary status word holds the primary flags in bits [NUM_PRI-1:0]. The extended status word holds the extended flags in bits [NUM_EXT-1:0]. The enable words hold the enables in the same low bits.
- R6: A read of the primary status word clears all primary flags at the clock edge where `rd_en` is first seen low. Reads of the other words clear nothing.
- R7: A primary event that occurs while a primary-status read is open leaves the flags and `irq_n` unchanged until the read ends. It is then set into its flag at the closing edge.
- R8: Extended flags are not changed by any read. A write to the extended status word clears each bit written as 0. Bits written as 1 keep their value, so software cannot set a flag.
- R9: Bit DATA_W-1 of the primary status word is the summary bit. It reads 1 when, at the rising edge of `rd_en`, any source of either group had both flag and enable set.
- R10: When an extended event arrives in the same cycle as a write of 0 to its bit, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register selector for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable; high for the length of a read cycle |
| rd_data | output | DATA_W | Read word latched at the rising edge of rd_en |
| pri_evt | input | NUM_PRI | Primary event pulses |
| ext_evt | input | NUM_EXT | Extended event pulses |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: three primary and three extended sources, an eight-bit data word, and the combinational request output. This puts the summary bit at bit 7 with the flags in bits 2:0, so every vector's expected value is a plain byte. It also means a change of `irq_n` can be sampled one edge after the register write or event that causes it. With this configuration the bench can reach the collisions: an event arriving while a read is open, an event arriving in the read's closing cycle, and an event arriving in the same cycle as a write of zero.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   typedef enum logic [1:0] {
      REG_PRI_EN   = 2'd0,
      REG_PRI_STAT = 2'd1,
      REG_EXT_EN   = 2'd2,
      REG_EXT_STAT = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/rtc_irq_pri_bank.sv
// Read-to-clear flag bank with a side register that keeps events seen during a read.
module rtc_irq_pri_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         hold,
   input  logic         release_rd,
   output logic [N-1:0] flags_o
);
   if (N < 1) begin : g_bad_n
      $error("rtc_irq_pri_bank: N must be at least 1");
   end

   logic [N-1:0] flag_q;
   logic [N-1:0] pend_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
            pend_q[i] <= 1'b0;
         end else if (release_rd) begin
            flag_q[i] <= pend_q[i] | evt[i];
            pend_q[i] <= 1'b0;
         end else if (hold) begin
            if (evt[i]) pend_q[i] <= 1'b1;
         end else begin
            if (evt[i]) flag_q[i] <= 1'b1;
         end
      end

      // R2: an event outside a read sets the flag
      a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (!hold && evt[i]) |=> flag_q[i]);
   end

   assign flags_o = flag_q;

   // R7: flags stay frozen while a status read is open
   a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(flag_q));
endmodule

// File: rtl/rtc_irq_ext_bank.sv
// Write-zero-to-clear flag bank; reads never touch it.
module rtc_irq_ext_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         clr_wr,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] flags_o
);
   if (N < 1) begin : g_bad_n
      $error("rtc_irq_ext_bank: N must be at least 1");
   end

   logic [N-1:0] flag_q;
   logic [N-1:0] keep_mask;

   assign keep_mask = clr_wr ? wdata : {N{1'b1}};

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= (flag_q[i] & keep_mask[i]) | evt[i];
      end

      // R8: writing 1 keeps a set flag
      a_r8_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && wdata[i] && flag_q[i]) |=> flag_q[i]);
      // R10: an event wins over a same-cycle clear
      a_r10_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> flag_q[i]);
   end

   assign flags_o = flag_q;

   // R8: without a clearing write no flag falls
   a_r8_no_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (($past(flag_q) & ~flag_q) == '0));
endmodule

// File: rtl/rtc_irq_regif.sv
// Register access: enables, read-window tracking and the latched read word.
module rtc_irq_regif
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_PRI = 3,
   parameter int NUM_EXT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         addr,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   input  logic [NUM_PRI-1:0] pri_flags,
   input  logic [NUM_EXT-1:0] ext_flags,
   input  logic               irq_active,
   output logic [NUM_PRI-1:0] pri_en_o,
   output logic [NUM_EXT-1:0] ext_en_o,
   output logic               hold_o,
   output logic               release_o,
   output logic               ext_clr_wr_o,
   output logic [NUM_EXT-1:0] ext_wdata_o,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int MAXN = (NUM_PRI > NUM_EXT) ? NUM_PRI : NUM_EXT;

   if (NUM_PRI + 1 > DATA_W) begin : g_bad_pri
      $error("rtc_irq_regif: primary flags and summary bit exceed DATA_W");
   end
   if (NUM_EXT + 1 > DATA_W) begin : g_bad_ext
      $error("rtc_irq_regif: NUM_EXT must be below DATA_W");
   end

   reg_sel_e sel;
   logic rd_en_q, stat_rd_q, rd_rise, is_stat;
   logic [NUM_PRI-1:0] pri_en_q;
   logic [NUM_EXT-1:0] ext_en_q;
   logic [DATA_W-1:0]  rd_word;
   logic               unused_wr_hi;

   assign sel     = reg_sel_e'(addr);
   assign rd_rise = rd_en & ~rd_en_q;
   assign is_stat = (sel == REG_PRI_STAT);

   assign hold_o       = rd_en & ((rd_rise & is_stat) | stat_rd_q);
   assign release_o    = stat_rd_q & ~rd_en;
   assign ext_clr_wr_o = wr_en & (sel == REG_EXT_STAT);
   assign ext_wdata_o  = wr_data[NUM_EXT-1:0];
   assign unused_wr_hi = ^wr_data[DATA_W-1:MAXN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_en_q   <= 1'b0;
         stat_rd_q <= 1'b0;
      end else begin
         rd_en_q <= rd_en;
         if (rd_rise)     stat_rd_q <= is_stat;
         else if (!rd_en) stat_rd_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_en_q <= '0;
         ext_en_q <= '0;
      end else if (wr_en) begin
         if (sel == REG_PRI_EN) pri_en_q <= wr_data[NUM_PRI-1:0];
         if (sel == REG_EXT_EN) ext_en_q <= wr_data[NUM_EXT-1:0];
      end
   end

   always_comb begin
      rd_word = '0;
      unique case (sel)
         REG_PRI_EN:   rd_word[NUM_PRI-1:0] = pri_en_q;
         REG_PRI_STAT: begin
            rd_word[NUM_PRI-1:0] = pri_flags;
            rd_word[DATA_W-1]    = irq_active;
         end
         REG_EXT_EN:   rd_word[NUM_EXT-1:0] = ext_en_q;
         REG_EXT_STAT: rd_word[NUM_EXT-1:0] = ext_flags;
         default:      rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data <= '0;
      else if (rd_rise) rd_data <= rd_word;
   end

   assign pri_en_o = pri_en_q;
   assign ext_en_o = ext_en_q;

   // R5: the read word holds while the read stays open
   a_r5_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_en_q) |=> $stable(rd_data));
   // R6: a primary-status read closes in the cycle rd_en is seen low
   a_r6_release_once: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |=> !release_o);
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Top: two flag banks, register interface, request line.
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_PRI = 3,
   parameter int NUM_EXT = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         addr,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_PRI-1:0] pri_evt,
   input  logic [NUM_EXT-1:0] ext_evt,
   output logic               irq_n
);
   logic [NUM_PRI-1:0] pri_flags, pri_en;
   logic [NUM_EXT-1:0] ext_flags, ext_en, ext_wdata;
   logic hold, release_rd, ext_clr_wr, irq_active;

   rtc_irq_pri_bank #(.N(NUM_PRI)) u_pri (
      .clk(clk), .rst_n(rst_n), .evt(pri_evt), .hold(hold),
      .release_rd(release_rd), .flags_o(pri_flags));

   rtc_irq_ext_bank #(.N(NUM_EXT)) u_ext (
      .clk(clk), .rst_n(rst_n), .evt(ext_evt), .clr_wr(ext_clr_wr),
      .wdata(ext_wdata), .flags_o(ext_flags));

   rtc_irq_regif #(.DATA_W(DATA_W), .NUM_PRI(NUM_PRI), .NUM_EXT(NUM_EXT)) u_regif (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .pri_flags(pri_flags), .ext_flags(ext_flags),
      .irq_active(irq_active), .pri_en_o(pri_en), .ext_en_o(ext_en),
      .hold_o(hold), .release_o(release_rd), .ext_clr_wr_o(ext_clr_wr),
      .ext_wdata_o(ext_wdata), .rd_data(rd_data));

   assign irq_active = (|(pri_flags & pri_en)) | (|(ext_flags & ext_en));

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= ~irq_active;
      end
      assign irq_n = irq_q;
   end else begin : g_irq_comb
      assign irq_n = ~irq_active;

      // R4: enabling an already flagged extended source asserts the line next cycle
      a_r4_enable_flagged: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == REG_EXT_EN && |(wr_data[NUM_EXT-1:0] & ext_flags)) |=> !irq_n);
      // R3: with both enable words zero the line stays released
      a_r3_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (pri_en == '0 && ext_en == '0) |-> irq_n);
   end
endmodule

// File: tb/tb_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rtc_irq_ctrl;
   localparam int DW = 8;
   localparam logic [1:0] OP_ID = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

   typedef struct packed {
      logic [1:0] op;
      logic [1:0] addr;
      logic [7:0] data;
      logic [2:0] pevt;
      logic [2:0] eevt;
      logic [7:0] exp_rd;
      logic       exp_irqn;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t TBL [NV] = '{
      '{OP_RD, 2'd1, 8'h00, 3'b000, 3'b000, 8'h00, 1'b1, 8'd1},  // R1 primary status zero
      '{OP_RD, 2'd3, 8'h00, 3'b000, 3'b000, 8'h00, 1'b1, 8'd1},  // R1 extended status zero
      '{OP_ID, 2'd0, 8'h00, 3'b001, 3'b000, 8'h00, 1'b1, 8'd2},  // R2 flag without enable
      '{OP_RD, 2'd1, 8'h00, 3'b000, 3'b000, 8'h01, 1'b1, 8'd2},  // R2 polled flag
      '{OP_RD, 2'd1, 8'h00, 3'b000, 3'b000, 8'h00, 1'b1, 8'd6},  // R6 cleared by read
      '{OP_ID, 2'd0, 8'h00, 3'b010, 3'b000, 8'h00, 1'b1, 8'd2},
      '{OP_WR, 2'd0, 8'h02, 3'b000, 3'b000, 8'h00, 1'b0, 8'd4},  // R4 enable flagged source
      '{OP_RD, 2'd0, 8'h00, 3'b000, 3'b000, 8'h02, 1'b0, 8'd6},  // R6 enable read clears nothing
      '{OP_RD, 2'd1, 8'h00, 3'b000, 3'b000, 8'h82, 1'b1, 8'd9},  // R9 summary bit
      '{OP_ID, 2'd0, 8'h00, 3'b000, 3'b100, 8'h00, 1'b1, 8'd3},  // R3 masked
      '{OP_WR, 2'd2, 8'h04, 3'b000, 3'b000, 8'h00, 1'b0, 8'd4},  // R4 extended enable
      '{OP_RD, 2'd3, 8'h00, 3'b000, 3'b000, 8'h04, 1'b0, 8'd8},  // R8 read keeps flag
      '{OP_RD, 2'd1, 8'h00, 3'b000, 3'b000, 8'h80, 1'b0, 8'd9},  // R9 summary from extended
      '{OP_WR, 2'd3, 8'hFF, 3'b000, 3'b000, 8'h00, 1'b0, 8'd8},  // R8 ones keep
      '{OP_WR, 2'd3, 8'h0B, 3'b000, 3'b000, 8'h00, 1'b1, 8'd8},  // R8 zero clears bit 2
      '{OP_RD, 2'd3, 8'h00, 3'b000, 3'b000, 8'h00, 1'b1, 8'd8},
      '{OP_ID, 2'd0, 8'h00, 3'b000, 3'b011, 8'h00, 1'b1, 8'd3},
      '{OP_WR, 2'd3, 8'h02, 3'b000, 3'b000, 8'h00, 1'b1, 8'd8},  // R8 per-bit clear
      '{OP_RD, 2'd3, 8'h00, 3'b000, 3'b000, 8'h02, 1'b1, 8'd8},
      '{OP_ID, 2'd0, 8'h00, 3'b100, 3'b000, 8'h00, 1'b1, 8'd3},  // R3 flag but not enabled
      '{OP_WR, 2'd0, 8'h06, 3'b000, 3'b000, 8'h00, 1'b0, 8'd3},
      '{OP_WR, 2'd0, 8'h02, 3'b000, 3'b000, 8'h00, 1'b1, 8'd3},  // R3 disable releases
      '{OP_RD, 2'd1, 8'h00, 3'b000, 3'b000, 8'h04, 1'b1, 8'd9},
      '{OP_WR, 2'd3, 8'h00, 3'b000, 3'b001, 8'h00, 1'b1, 8'd10}, // R10 event beats clear
      '{OP_RD, 2'd3, 8'h00, 3'b000, 3'b000, 8'h01, 1'b1, 8'd10}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [2:0] pri_evt = '0, ext_evt = '0;
   logic irq_n;
   int errors = 0, checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rtc_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pri_evt(pri_evt), .ext_evt(ext_evt),
      .irq_n(irq_n));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] a, input string req, input logic [7:0] exp);
      addr = a; rd_en = 1'b1;
      tick();
      check(req, rd_data, exp);
      rd_en = 1'b0;
      tick();
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
      rst_n = 1'b1;
      tick();
      check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", TBL[v].req, v);
         pri_evt = TBL[v].pevt;
         ext_evt = TBL[v].eevt;
         addr    = TBL[v].addr;
         case (TBL[v].op)
            OP_WR: begin
               wr_data = TBL[v].data; wr_en = 1'b1;
               tick();
               wr_en = 1'b0;
            end
            OP_RD: begin
               rd_en = 1'b1;
               tick();
               check({tag, " rd_data"}, rd_data, TBL[v].exp_rd);
               rd_en = 1'b0;
               tick();
            end
            default: tick();
         endcase
         pri_evt = '0;
         ext_evt = '0;
         check({tag, " irq_n"}, {7'd0, irq_n}, {7'd0, TBL[v].exp_irqn});
      end

      // R7: event held across an open primary-status read
      do_write(2'd0, 8'h04);
      pri_evt = 3'b001;
      tick();
      pri_evt = '0;
      addr = 2'd1; rd_en = 1'b1;
      tick();
      check("R5 snapshot", rd_data, 8'h01);
      pri_evt = 3'b100;
      tick();
      pri_evt = '0;
      check("R5 snapshot stable", rd_data, 8'h01);
      check("R7 irq_n held during read", {7'd0, irq_n}, 8'h01);
      tick();
      rd_en = 1'b0;
      tick();
      check("R7 irq_n after read closes", {7'd0, irq_n}, 8'h00);
      do_read(2'd1, "R7 posted event with summary", 8'h84);
      check("R6 cleared after read", {7'd0, irq_n}, 8'h01);

      // R7: event in the closing cycle is posted
      addr = 2'd1; rd_en = 1'b1;
      tick();
      rd_en = 1'b0; pri_evt = 3'b100;
      tick();
      pri_evt = '0;
      check("R7 closing-cycle event", {7'd0, irq_n}, 8'h00);
      do_read(2'd1, "R7 closing-cycle flag", 8'h84);

      // R1: reset mid-run
      pri_evt = 3'b111; ext_evt = 3'b111;
      tick();
      pri_evt = '0; ext_evt = '0;
      do_write(2'd0, 8'h07);
      check("R3 asserted before reset", {7'd0, irq_n}, 8'h00);
      rst_n = 1'b0;
      tick();
      check("R1 irq_n on reset", {7'd0, irq_n}, 8'h01);
      rst_n = 1'b1;
      tick();
      do_read(2'd0, "R1 primary enable", 8'h00);
      do_read(2'd1, "R1 primary flags", 8'h00);
      do_read(2'd2, "R1 extended enable", 8'h00);
      do_read(2'd3, "R1 extended flags", 8'h00);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule